// File: doc/BRIEF.md
# UART Channel FIFO Controller with DMA Request Signalling

This block holds the transmit and receive byte queues of one UART channel and the control logic around them. A host writes an 8-bit control byte that switches the queues between full-depth operation and single-byte holding mode, empties either queue on demand, selects one of two DMA request modes, and picks a fill threshold for each direction from a small encoded set. Four extra 8-bit registers can take over the threshold choice. The block reports a threshold flag for each direction and two active-low DMA request lines. It does not contain the serial shifters, the baud generator, the receive timeout timer or any interrupt arbitration.

Data moves through four valid/ready ports. The host writes bytes into the transmit queue and the transmitter takes them out. The receiver writes bytes into the receive queue and the host takes them out. A write port accepts a byte on a clock edge where valid and ready are both high. Ready is low only while the queue is full, so a producer that sees ready low must hold its byte and retry. A read port hands over its head byte on an edge where valid and ready are both high. Valid means the queue is not empty, and the data is stable until that byte is taken. Control and status pins are plain levels or strobes.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset the queues are disabled (control bit 0 = 0), both counts are 0, DMA mode is 0, `rxrdy_n` is 1 and `txrdy_n` is 0.
- R2: With control bit 0 = 1, each queue holds up to DEPTH (32) bytes in first-in first-out order. Write-side ready is low exactly when the queue is full, and the count follows the accepted writes and reads.
- R3: With control bit 0 = 0, each queue holds at most one byte, so write-side ready is low whenever the count is nonzero.
- R4: A write offered to a full queue, or a read requested from an empty queue, leaves the queue unchanged. It raises that queue's overflow or underflow flag for exactly the following cycle.
- R5: A control write with bit 1 = 1 empties the receive queue, and one with bit 2 = 1 empties the transmit queue, on that edge. Any byte offered in the same cycle is discarded. These bits are not retained, so later writes with them at 0 clear nothing.
- R6: Unless overridden, the receive threshold comes from control bits 7:6 (00→8, 01→16, 10→24, 11→28 bytes), and `rx_trig` is high while the receive count is at least the threshold.
- R7: Unless overridden, the transmit threshold comes from control bits 5:4 (00→16, 01→8, 10→24, 11→30 free entries), and `tx_trig` is high while the free space is at least the threshold. Free space is capacity minus count, and 0 when the count is at or above capacity.
- R8: Extended registers are written with `ext_we`, where `ext_sel` 0 is the RX level, 1 is the TX level, and 2 and 3 are the two flow-level registers. While any of the four is nonzero, the RX and TX level registers replace the encoded thresholds.
- R9: In DMA mode 1 (control bits 0 and 3 both 1), `rxrdy_n` goes low when the receive queue is nonempty and either `rx_trig` is high or `rx_timeout` pulses. It then stays low until the receive queue is empty.
- R10: In DMA mode 1, `txrdy_n` goes low while `tx_trig` is high and the transmit queue is not full, and then stays low until the queue is full. It is high whenever the queue is full.
- R11: Outside DMA mode 1, `rxrdy_n` is low exactly when the receive queue is nonempty, and `txrdy_n` is low exactly when the transmit queue is empty.
- R12: `fifo_en` shows control bit 0, and `dma_mode` is high exactly when control bits 0 and 3 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fcr_we | input | 1 | Control byte write strobe |
| fcr_wdata | input | 8 | Control byte |
| ext_we | input | 1 | Extended register write strobe |
| ext_sel | input | 2 | Extended register select (0 RX level, 1 TX level, 2/3 flow levels) |
| ext_wdata | input | 8 | Extended register data |
| tx_in_valid | input | 1 | Host offers a transmit byte |
| tx_in_data | input | 8 | Transmit byte from host |
| tx_in_ready | output | 1 | Transmit queue can accept |
| tx_out_valid | output | 1 | Transmit queue has a byte |
| tx_out_data | output | 8 | Head of transmit queue |
| tx_out_ready | input | 1 | Transmitter takes the head byte |
| rx_in_valid | input | 1 | Receiver offers a byte |
| rx_in_data | input | 8 | Received byte |
| rx_in_ready | output | 1 | Receive queue can accept |
| rx_out_valid | output | 1 | Receive queue has a byte |
| rx_out_data | output | 8 | Head of receive queue |
| rx_out_ready | input | 1 | Host takes the head byte |
| rx_timeout | input | 1 | Receive timeout pulse |
| tx_count | output | 6 | Bytes in transmit queue |
| rx_count | output | 6 | Bytes in receive queue |
| rx_trig | output | 1 | Receive threshold reached |
| tx_trig | output | 1 | Transmit free-space threshold reached |
| rxrdy_n | output | 1 | Receive DMA request, active low |
| txrdy_n | output | 1 | Transmit DMA request, active low |
| fifo_en | output | 1 | Queues enabled |
| dma_mode | output | 1 | DMA mode 1 active |
| tx_ovf | output | 1 | Transmit write dropped last cycle |
| tx_unf | output | 1 | Transmit read on empty last cycle |
| rx_ovf | output | 1 | Receive write dropped last cycle |
| rx_unf | output | 1 | Receive read on empty last cycle |

## Verification
The bench builds the block with its default DEPTH of 32 and byte width of 8, so the encoded thresholds come out as 8/16/24/28 and 16/8/24/30. These are the values R6 and R7 name. With a 32-entry queue, random phases with heavy write bias fill a queue to its top, which reaches the 28-byte receive threshold, the 30-entry transmit threshold and the full-queue overflow path. Phases with heavy read bias drain it again, which lets the mode-1 hold release at empty. Because the override levels are 8 bits wide, they can name thresholds above the queue depth or of zero, and the random extended-register writes reach both.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  typedef enum logic [1:0] {
    EXT_RX_LEVEL = 2'd0,
    EXT_TX_LEVEL = 2'd1,
    EXT_FLOW_HI  = 2'd2,
    EXT_FLOW_LO  = 2'd3
  } ext_sel_e;

  typedef struct packed {
    logic [1:0] rx_sel;
    logic [1:0] tx_sel;
    logic       dma_sel;
    logic       enable;
  } ctl_t;
endpackage

// File: rtl/ufc_fifo.sv
module ufc_fifo #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         cap_one,
  input  logic                         in_valid,
  input  logic [WIDTH-1:0]             in_data,
  output logic                         in_ready,
  output logic                         out_valid,
  output logic [WIDTH-1:0]             out_data,
  input  logic                         out_ready,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         ovf,
  output logic                         unf
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             empty, do_push, do_pop;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty     = (count == '0);
  assign full      = cap_one ? !empty : (count == CW'(DEPTH));
  assign in_ready  = !full;
  assign out_valid = !empty;
  assign out_data  = mem[rd_ptr];
  assign do_push   = in_valid && !full && !clr;
  assign do_pop    = out_ready && !empty && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
      unf    <= 1'b0;
    end else begin
      ovf <= in_valid && full && !clr;
      unf <= out_ready && empty;
      if (clr) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
        count  <= '0;
      end else begin
        if (do_push) wr_ptr <= ptr_next(wr_ptr);
        if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
        case ({do_push, do_pop})
          2'b10:   count <= count + 1'b1;
          2'b01:   count <= count - 1'b1;
          default: count <= count;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= in_data;
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_drop_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && full && !clr) |=> ovf);
  assert_drop_keeps_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && full && !clr && !(out_ready && !empty)) |=> $stable(count));
  assert_clear_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));
endmodule

// File: rtl/ufc_trig.sv
module ufc_trig #(
  parameter int DEPTH = 32
) (
  input  logic [1:0]                 rx_sel,
  input  logic [1:0]                 tx_sel,
  input  logic                       ovr_active,
  input  logic [7:0]                 rx_ovr,
  input  logic [7:0]                 tx_ovr,
  input  logic                       cap_one,
  input  logic [$clog2(DEPTH+1)-1:0] rx_count,
  input  logic [$clog2(DEPTH+1)-1:0] tx_count,
  output logic                       rx_trig,
  output logic                       tx_trig
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int MW = ((CW > 8) ? CW : 8) + 1;

  logic [MW-1:0] rx_enc, tx_enc, rx_level, tx_level, cap, txc, free;

  always_comb begin
    case (rx_sel)
      2'd0:    rx_enc = MW'(DEPTH / 4);
      2'd1:    rx_enc = MW'(DEPTH / 2);
      2'd2:    rx_enc = MW'((3 * DEPTH) / 4);
      default: rx_enc = MW'(DEPTH - DEPTH / 8);
    endcase
    case (tx_sel)
      2'd0:    tx_enc = MW'(DEPTH / 2);
      2'd1:    tx_enc = MW'(DEPTH / 4);
      2'd2:    tx_enc = MW'((3 * DEPTH) / 4);
      default: tx_enc = MW'(DEPTH - DEPTH / 16);
    endcase
  end

  assign rx_level = ovr_active ? MW'(rx_ovr) : rx_enc;
  assign tx_level = ovr_active ? MW'(tx_ovr) : tx_enc;
  assign cap      = cap_one ? MW'(1) : MW'(DEPTH);
  assign txc      = MW'(tx_count);
  assign free     = (txc >= cap) ? '0 : cap - txc;
  assign rx_trig  = MW'(rx_count) >= rx_level;
  assign tx_trig  = free >= tx_level;
endmodule

// File: rtl/ufc_dma.sv
module ufc_dma (
  input  logic clk,
  input  logic rst_n,
  input  logic mode1,
  input  logic rx_nonempty,
  input  logic rx_trig,
  input  logic rx_timeout,
  input  logic tx_empty,
  input  logic tx_full,
  input  logic tx_trig,
  output logic rxrdy_n,
  output logic txrdy_n
);
  logic rx_hold_q, tx_hold_q, rx_req, tx_req;

  assign rx_req  = mode1 && rx_nonempty && (rx_hold_q || rx_trig || rx_timeout);
  assign tx_req  = mode1 && !tx_full && (tx_hold_q || tx_trig);
  assign rxrdy_n = mode1 ? !rx_req : !rx_nonempty;
  assign txrdy_n = mode1 ? !tx_req : !tx_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_hold_q <= 1'b0;
      tx_hold_q <= 1'b0;
    end else begin
      rx_hold_q <= rx_req;
      tx_hold_q <= tx_req;
    end
  end

  assert_rx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode1 && !rxrdy_n) |=> (!(mode1 && rx_nonempty) || !rxrdy_n));
  assert_tx_full_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode1 && tx_full) |-> txrdy_n);
  assert_tx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode1 && !txrdy_n) |=> (!mode1 || tx_full || !txrdy_n));
  assert_mode0_rx_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode1 && !rx_nonempty) |-> rxrdy_n);
endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int WIDTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fcr_we,
  input  logic [7:0]                 fcr_wdata,
  input  logic                       ext_we,
  input  logic [1:0]                 ext_sel,
  input  logic [7:0]                 ext_wdata,
  input  logic                       tx_in_valid,
  input  logic [WIDTH-1:0]           tx_in_data,
  output logic                       tx_in_ready,
  output logic                       tx_out_valid,
  output logic [WIDTH-1:0]           tx_out_data,
  input  logic                       tx_out_ready,
  input  logic                       rx_in_valid,
  input  logic [WIDTH-1:0]           rx_in_data,
  output logic                       rx_in_ready,
  output logic                       rx_out_valid,
  output logic [WIDTH-1:0]           rx_out_data,
  input  logic                       rx_out_ready,
  input  logic                       rx_timeout,
  output logic [$clog2(DEPTH+1)-1:0] tx_count,
  output logic [$clog2(DEPTH+1)-1:0] rx_count,
  output logic                       rx_trig,
  output logic                       tx_trig,
  output logic                       rxrdy_n,
  output logic                       txrdy_n,
  output logic                       fifo_en,
  output logic                       dma_mode,
  output logic                       tx_ovf,
  output logic                       tx_unf,
  output logic                       rx_ovf,
  output logic                       rx_unf
);
  localparam int NEXT = 4;

  ctl_t       ctl_q;
  logic [7:0] ext_q [NEXT];
  logic       ovr_active, rx_clr, tx_clr, cap_one, tx_full, rx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (fcr_we) begin
      ctl_q.rx_sel  <= fcr_wdata[7:6];
      ctl_q.tx_sel  <= fcr_wdata[5:4];
      ctl_q.dma_sel <= fcr_wdata[3];
      ctl_q.enable  <= fcr_wdata[0];
    end
  end

  generate
    for (genvar g = 0; g < NEXT; g++) begin : g_ext
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ext_q[g] <= '0;
        else if (ext_we && (ext_sel == 2'(g))) ext_q[g] <= ext_wdata;
      end
    end
  endgenerate

  assign ovr_active = |{ext_q[EXT_RX_LEVEL], ext_q[EXT_TX_LEVEL],
                        ext_q[EXT_FLOW_HI], ext_q[EXT_FLOW_LO]};
  assign rx_clr   = fcr_we && fcr_wdata[1];
  assign tx_clr   = fcr_we && fcr_wdata[2];
  assign cap_one  = !ctl_q.enable;
  assign fifo_en  = ctl_q.enable;
  assign dma_mode = ctl_q.enable && ctl_q.dma_sel;

  ufc_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr), .cap_one(cap_one),
    .in_valid(tx_in_valid), .in_data(tx_in_data), .in_ready(tx_in_ready),
    .out_valid(tx_out_valid), .out_data(tx_out_data), .out_ready(tx_out_ready),
    .count(tx_count), .full(tx_full), .ovf(tx_ovf), .unf(tx_unf));

  ufc_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr), .cap_one(cap_one),
    .in_valid(rx_in_valid), .in_data(rx_in_data), .in_ready(rx_in_ready),
    .out_valid(rx_out_valid), .out_data(rx_out_data), .out_ready(rx_out_ready),
    .count(rx_count), .full(rx_full), .ovf(rx_ovf), .unf(rx_unf));

  ufc_trig #(.DEPTH(DEPTH)) u_trig (
    .rx_sel(ctl_q.rx_sel), .tx_sel(ctl_q.tx_sel), .ovr_active(ovr_active),
    .rx_ovr(ext_q[EXT_RX_LEVEL]), .tx_ovr(ext_q[EXT_TX_LEVEL]),
    .cap_one(cap_one), .rx_count(rx_count), .tx_count(tx_count),
    .rx_trig(rx_trig), .tx_trig(tx_trig));

  ufc_dma u_dma (
    .clk(clk), .rst_n(rst_n), .mode1(dma_mode),
    .rx_nonempty(rx_out_valid), .rx_trig(rx_trig), .rx_timeout(rx_timeout),
    .tx_empty(!tx_out_valid), .tx_full(tx_full), .tx_trig(tx_trig),
    .rxrdy_n(rxrdy_n), .txrdy_n(txrdy_n));

  assert_cap_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && (rx_count != '0)) |-> !rx_in_ready);
  assert_dma_needs_enable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    dma_mode |-> fifo_en);
  assert_self_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fcr_we && tx_out_valid && !tx_out_ready) |=> tx_out_valid);
endmodule

// File: tb/sim_uart_fifo_ctl.sv
module sim_uart_fifo_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       fcr_we = 0, ext_we = 0, tx_in_valid = 0, tx_out_ready = 0;
  logic       rx_in_valid = 0, rx_out_ready = 0, rx_timeout = 0;
  logic [7:0] fcr_wdata = 0, ext_wdata = 0, tx_in_data = 0, rx_in_data = 0;
  logic [1:0] ext_sel = 0;
  logic       tx_in_ready, tx_out_valid, rx_in_ready, rx_out_valid;
  logic [7:0] tx_out_data, rx_out_data;
  logic [5:0] tx_count, rx_count;
  logic       rx_trig, tx_trig, rxrdy_n, txrdy_n, fifo_en, dma_mode;
  logic       tx_ovf, tx_unf, rx_ovf, rx_unf;

  uart_fifo_ctl u0 (.*);

  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit done = 0;

  byte unsigned tq[$], rq[$];
  bit m_en = 0, m_dma = 0, m_rxh = 0, m_txh = 0, tclr_prev = 0, rclr_prev = 0;
  int m_rxs = 0, m_txs = 0;
  int m_ext[4] = '{0, 0, 0, 0};
  bit e_tovf = 0, e_tunf = 0, e_rovf = 0, e_runf = 0;

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit ovr();
    return (m_ext[0] | m_ext[1] | m_ext[2] | m_ext[3]) != 0;
  endfunction
  function automatic int rx_lvl();
    int t[4] = '{8, 16, 24, 28};
    return ovr() ? m_ext[0] : t[m_rxs];
  endfunction
  function automatic int tx_lvl();
    int t[4] = '{16, 8, 24, 30};
    return ovr() ? m_ext[1] : t[m_txs];
  endfunction
  function automatic int cap();
    return m_en ? 32 : 1;
  endfunction
  function automatic int free_sp();
    return (tq.size() >= cap()) ? 0 : cap() - tq.size();
  endfunction

  task automatic run_cycle();
    int tn, rn; bit tfull, rfull, m1, rtrig, ttrig, rreq, treq, tclr, rclr;
    string qt_t, qt_r, tg_r, tg_t;
    #1;
    tn = tq.size(); rn = rq.size();
    tfull = tn >= cap(); rfull = rn >= cap();
    m1 = m_en && m_dma;
    rtrig = rn >= rx_lvl();
    ttrig = free_sp() >= tx_lvl();
    rreq = m1 && rn != 0 && (m_rxh || rtrig || rx_timeout);
    treq = m1 && !tfull && (m_txh || ttrig);
    qt_t = tclr_prev ? "R5" : (m_en ? "R2" : "R3");
    qt_r = rclr_prev ? "R5" : (m_en ? "R2" : "R3");
    chk(qt_t, tx_count, tn);
    chk(qt_r, rx_count, rn);
    chk(qt_t, tx_in_ready, !tfull);
    chk(qt_r, rx_in_ready, !rfull);
    chk(qt_t, tx_out_valid, tn != 0);
    chk(qt_r, rx_out_valid, rn != 0);
    if (tn != 0) chk("R2", tx_out_data, tq[0]);
    if (rn != 0) chk("R2", rx_out_data, rq[0]);
    tg_r = ovr() ? "R8" : "R6";
    tg_t = ovr() ? "R8" : "R7";
    chk(tg_r, rx_trig, rtrig);
    chk(tg_t, tx_trig, ttrig);
    chk(m1 ? "R9" : "R11", rxrdy_n, m1 ? !rreq : rn == 0);
    chk(m1 ? "R10" : "R11", txrdy_n, m1 ? !treq : tn != 0);
    chk("R12", fifo_en, m_en);
    chk("R12", dma_mode, m1);
    chk("R4", tx_ovf, e_tovf); chk("R4", tx_unf, e_tunf);
    chk("R4", rx_ovf, e_rovf); chk("R4", rx_unf, e_runf);
    // model update, as of the coming edge
    tclr = fcr_we && fcr_wdata[2];
    rclr = fcr_we && fcr_wdata[1];
    m_rxh = rreq; m_txh = treq;
    e_tovf = tx_in_valid && tfull && !tclr; e_tunf = tx_out_ready && tn == 0;
    e_rovf = rx_in_valid && rfull && !rclr; e_runf = rx_out_ready && rn == 0;
    if (tclr) tq.delete();
    else begin
      if (tx_out_ready && tn != 0) void'(tq.pop_front());
      if (tx_in_valid && !tfull) tq.push_back(tx_in_data);
    end
    if (rclr) rq.delete();
    else begin
      if (rx_out_ready && rn != 0) void'(rq.pop_front());
      if (rx_in_valid && !rfull) rq.push_back(rx_in_data);
    end
    if (fcr_we) begin
      m_en = fcr_wdata[0]; m_dma = fcr_wdata[3];
      m_txs = int'(fcr_wdata[5:4]); m_rxs = int'(fcr_wdata[7:6]);
    end
    if (ext_we) m_ext[ext_sel] = int'(ext_wdata);
    tclr_prev = tclr; rclr_prev = rclr;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    fcr_we = 0; ext_we = 0; tx_in_valid = 0; tx_out_ready = 0;
    rx_in_valid = 0; rx_out_ready = 0; rx_timeout = 0;
  endtask

  task automatic wr_fcr(logic [7:0] v);
    idle(); fcr_we = 1; fcr_wdata = v; run_cycle(); idle();
  endtask
  task automatic wr_ext(int s, int v);
    idle(); ext_we = 1; ext_sel = 2'(s); ext_wdata = 8'(v); run_cycle(); idle();
  endtask
  task automatic push_both(int n);
    for (int i = 0; i < n; i++) begin
      idle(); tx_in_valid = 1; rx_in_valid = 1;
      tx_in_data = 8'($urandom); rx_in_data = 8'($urandom); run_cycle();
    end
    idle();
  endtask
  task automatic pop_both(int n);
    for (int i = 0; i < n; i++) begin
      idle(); tx_out_ready = 1; rx_out_ready = 1; run_cycle();
    end
    idle();
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_bad++;
        $display("FAIL watchdog: got %0d expected %0d", cycles, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h1f2e3d4c));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", fifo_en, 0); chk("R1", dma_mode, 0);
    chk("R1", tx_count, 0); chk("R1", rx_count, 0);
    chk("R1", rxrdy_n, 1); chk("R1", txrdy_n, 0);
    run_cycle();
    // R3 single-byte holding and R4 drops
    push_both(3);
    pop_both(3);
    // R2 full depth, overflow at 33rd byte
    wr_fcr(8'h01);
    push_both(34);
    pop_both(34);
    // R9/R10 mode 1 with rx 16 and tx 8
    wr_fcr(8'h59);
    push_both(20);
    pop_both(21);
    push_both(3);
    idle(); rx_timeout = 1; run_cycle(); idle();
    pop_both(4);
    // R5 clears, other queue untouched, then non-clearing write
    push_both(5);
    wr_fcr(8'hCB);
    wr_fcr(8'hC9);
    wr_fcr(8'hCD);
    wr_fcr(8'hC9);
    // R8 override levels
    wr_ext(3, 1); wr_ext(0, 5); wr_ext(1, 28);
    push_both(10);
    pop_both(11);
    wr_ext(0, 0); wr_ext(1, 0); wr_ext(3, 0);
    // random phases
    for (int ph = 0; ph < 24; ph++) begin
      int pin = ($urandom % 100), pout = ($urandom % 100);
      for (int c = 0; c < 150; c++) begin
        idle();
        tx_in_valid = ($urandom % 100) < pin;
        rx_in_valid = ($urandom % 100) < pin;
        tx_out_ready = ($urandom % 100) < pout;
        rx_out_ready = ($urandom % 100) < pout;
        tx_in_data = 8'($urandom); rx_in_data = 8'($urandom);
        rx_timeout = ($urandom % 40) == 0;
        if (($urandom % 60) == 0) begin
          fcr_we = 1;
          fcr_wdata = 8'($urandom) & 8'hF9;
          if (($urandom % 4) == 0) fcr_wdata[1] = 1;
          if (($urandom % 4) == 0) fcr_wdata[2] = 1;
          if (($urandom % 5) != 0) fcr_wdata[0] = 1;
        end
        if (($urandom % 90) == 0) begin
          ext_we = 1; ext_sel = 2'($urandom);
          ext_wdata = (($urandom % 2) == 0) ? 8'h00 : 8'($urandom % 40);
        end
        run_cycle();
      end
    end
    idle(); run_cycle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule